// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Interface

This block sits between a byte-wide host bus and the two channels of a serial communications controller. The host presents a 3-bit offset with read and write strobes and 8-bit data. The block decodes each access as a command-port or data-port access to channel A or channel B. It then forwards the access to that channel's register file port, its receive path or its transmit path.

Register selection uses an indirect scheme. Both channels share one register pointer. The first command write loads the pointer, and the following command access uses it and then returns it to zero. Register 2 is not a per-channel register. Command accesses at that index reach a single interrupt vector byte that both channels share and that this block holds. Data-port accesses exchange bytes with the receive and transmit paths directly and leave the pointer untouched.

Top module: `scc_hostif`

## Requirements
- R1: Offset decode is: offset bit 1 set selects a data port, clear selects a command port; offset bit 0 set selects channel A (index 1), clear selects channel B (index 0). So 0 is the B command port, 1 the A command port, 2 the B data port and 3 the A data port. At most one channel strobe (`reg_wr`, `rx_pop`, `tx_push`) is active in any cycle.
- R2: One pointer serves both channels and is visible on `reg_idx`. A pointer loaded through one channel's command port selects the register for the next command access on either channel. A command read returns `reg_rdata` of the addressed channel at index `reg_idx`.
- R3: Any command-port read returns the pointer to 0 on the following clock edge.
- R4: A command write while the pointer is 0 loads bits 3:0 of the written byte into the pointer and does not strobe `reg_wr`.
- R5: A command write while the pointer is nonzero and not 2 strobes `reg_wr` of the addressed channel with `reg_wdata` equal to the written byte, then clears the pointer.
- R6: With the pointer at 2, a command read on either channel returns the shared interrupt vector, and a command write loads the vector. Neither access strobes a channel register file.
- R7: A data-port read with `rx_avail` set for that channel returns `rx_data` and pulses `rx_pop`. With `rx_avail` clear it returns 0xFF and does not pop.
- R8: A data-port write pulses `tx_push` of the addressed channel with `tx_data` equal to the written byte.
- R9: Offsets 4 to 7 read as 0x00. Writes to them are dropped. Accesses there raise no strobe and leave the pointer unchanged.
- R10: Data-port accesses leave the pointer unchanged.
- R11: Reset clears the pointer and the interrupt vector to 0.
- R12: When `host_rd` and `host_wr` are both high, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Host register offset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle `host_rd` is high |
| reg_idx | output | 4 | Shared register pointer, register index for both channels |
| reg_wdata | output | 8 | Register file write data |
| reg_wr | output | 2 | Register file write strobe per channel (0 = B, 1 = A) |
| reg_rdata | input | 2x8 | Register file read data per channel at `reg_idx` |
| rx_avail | input | 2 | Receive byte available per channel |
| rx_data | input | 2x8 | Receive head byte per channel |
| rx_pop | output | 2 | Receive byte consumed per channel |
| tx_data | output | 8 | Transmit byte |
| tx_push | output | 2 | Transmit byte strobe per channel |

## Verification
The bench writes every register index of both channels through the pointer and reads each one back. For some reads it loads the pointer through the other channel's port. A design with per-channel pointers, or one that does not clear the pointer, would return the wrong channel's value or register 0's value. The bench reads the interrupt vector through both channels and counts register file strobes. A design that routed index 2 to a channel would return the channel's own byte and raise an extra write. It also drains the receive paths until they are empty, interleaves data-port and reserved-offset accesses with a pending pointer, and drives read and write together. Wrong-offset handling would show up as a lost pointer, a nonzero reserved read, or a stray transmit push.

// File: rtl/scc_hostif_pkg.sv
package scc_hostif_pkg;

  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CH_IDX_B = 0;
  localparam int unsigned CH_IDX_A = 1;

  // decoded host access, at most one of the four kinds is set
  typedef struct packed {
    logic cmd_rd;
    logic cmd_wr;
    logic dat_rd;
    logic dat_wr;
    logic ch;
  } hacc_t;

endpackage

// File: rtl/scc_hostif_rst_sync.sv
module scc_hostif_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/scc_hostif_dec.sv
module scc_hostif_dec
  import scc_hostif_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output hacc_t         acc
);

  logic in_map;
  logic wr_ok;

  always_comb begin
    in_map     = (addr[AW-1:2] == '0);
    wr_ok      = wr & ~rd;
    acc.cmd_rd = in_map & ~addr[1] & rd;
    acc.cmd_wr = in_map & ~addr[1] & wr_ok;
    acc.dat_rd = in_map &  addr[1] & rd;
    acc.dat_wr = in_map &  addr[1] & wr_ok;
    acc.ch     = addr[0];
  end

endmodule

// File: rtl/scc_hostif_ptr.sv
module scc_hostif_ptr
  import scc_hostif_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned PW      = 4,
  parameter int unsigned VEC_SEL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hacc_t         acc,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] ptr,
  output logic [DW-1:0] vec,
  output logic          ptr_is_vec
);

  localparam logic [PW-1:0] VEC_IDX = PW'(VEC_SEL);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] vec_q, vec_d;
  logic          ptr_en, vec_en;

  always_comb begin
    ptr_d  = ptr_q;
    vec_d  = vec_q;
    ptr_en = 1'b0;
    vec_en = 1'b0;
    if (acc.cmd_wr) begin
      ptr_en = 1'b1;
      if (ptr_q == '0) begin
        ptr_d = wdata[PW-1:0];
      end else begin
        ptr_d = '0;
        if (ptr_q == VEC_IDX) begin
          vec_en = 1'b1;
          vec_d  = wdata;
        end
      end
    end else if (acc.cmd_rd) begin
      ptr_en = 1'b1;
      ptr_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  assign ptr        = ptr_q;
  assign vec        = vec_q;
  assign ptr_is_vec = (ptr_q == VEC_IDX);

endmodule

// File: rtl/scc_hostif.sv
module scc_hostif
  import scc_hostif_pkg::*;
#(
  parameter int unsigned AW      = 3,
  parameter int unsigned DW      = 8,
  parameter int unsigned PW      = 4,
  parameter int unsigned VEC_SEL = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 host_addr,
  input  logic                          host_rd,
  input  logic                          host_wr,
  input  logic [DW-1:0]                 host_wdata,
  output logic [DW-1:0]                 host_rdata,
  output logic [PW-1:0]                 reg_idx,
  output logic [DW-1:0]                 reg_wdata,
  output logic [NUM_CH-1:0]             reg_wr,
  input  logic [NUM_CH-1:0][DW-1:0]     reg_rdata,
  input  logic [NUM_CH-1:0]             rx_avail,
  input  logic [NUM_CH-1:0][DW-1:0]     rx_data,
  output logic [NUM_CH-1:0]             rx_pop,
  output logic [DW-1:0]                 tx_data,
  output logic [NUM_CH-1:0]             tx_push
);

  logic          rst_sync_n;
  hacc_t         acc;
  logic [PW-1:0] ptr;
  logic [DW-1:0] vec;
  logic          ptr_is_vec;
  logic          ptr_zero;

  scc_hostif_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scc_hostif_dec #(.AW(AW)) u_dec (
    .addr (host_addr),
    .rd   (host_rd),
    .wr   (host_wr),
    .acc  (acc)
  );

  scc_hostif_ptr #(.DW(DW), .PW(PW), .VEC_SEL(VEC_SEL)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .acc        (acc),
    .wdata      (host_wdata),
    .ptr        (ptr),
    .vec        (vec),
    .ptr_is_vec (ptr_is_vec)
  );

  assign ptr_zero = (ptr == '0);

  // per-channel strobes
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel        = (acc.ch == 1'(c));
    assign reg_wr[c]  = acc.cmd_wr & sel & ~ptr_zero & ~ptr_is_vec;
    assign rx_pop[c]  = acc.dat_rd & sel & rx_avail[c];
    assign tx_push[c] = acc.dat_wr & sel;
  end

  // read data steering
  always_comb begin
    host_rdata = '0;
    if (acc.cmd_rd) begin
      host_rdata = ptr_is_vec ? vec : reg_rdata[acc.ch];
    end else if (acc.dat_rd) begin
      host_rdata = rx_avail[acc.ch] ? rx_data[acc.ch] : '1;
    end
  end

  assign reg_idx   = ptr;
  assign reg_wdata = host_wdata;
  assign tx_data   = host_wdata;

endmodule

// File: rtl/scc_hostif_chk.sv
module scc_hostif_chk #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [AW-1:0] host_addr,
  input logic          host_rd,
  input logic          host_wr,
  input logic [DW-1:0] host_wdata,
  input logic [DW-1:0] host_rdata,
  input logic [PW-1:0] reg_idx,
  input logic [1:0]    reg_wr,
  input logic [1:0]    rx_avail,
  input logic [1:0]    rx_pop,
  input logic [1:0]    tx_push
);

  logic rsv, cmd, dat, any;
  assign rsv = (host_addr[AW-1:2] != '0);
  assign cmd = ~rsv & ~host_addr[1];
  assign dat = ~rsv &  host_addr[1];
  assign any = host_rd | host_wr;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({reg_wr, rx_pop, tx_push}));  // R1

  AST_CMD_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_rd && cmd) |=> (reg_idx == '0));  // R3

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_wr && !host_rd && cmd && reg_idx == '0) |=> (reg_idx == $past(host_wdata[PW-1:0])));  // R4

  AST_PTR_LOAD_NO_WR: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_wr && cmd && reg_idx == '0) |-> (reg_wr == '0));  // R4

  AST_RX_EMPTY_FF: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_rd && dat && !rx_avail[host_addr[0]]) |-> (host_rdata == '1 && rx_pop == '0));  // R7

  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    (any && rsv) |-> (host_rdata == '0 && reg_wr == '0 && rx_pop == '0 && tx_push == '0));  // R9

  AST_RSV_KEEP_PTR: assert property (@(posedge clk) disable iff (!rst_ok)
    (any && rsv) |=> $stable(reg_idx));  // R9

  AST_DAT_KEEP_PTR: assert property (@(posedge clk) disable iff (!rst_ok)
    (any && dat) |=> $stable(reg_idx));  // R10

  AST_RD_WINS: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_rd && host_wr) |-> (tx_push == '0 && reg_wr == '0));  // R12

endmodule

bind scc_hostif scc_hostif_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .host_addr  (host_addr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .reg_idx    (reg_idx),
  .reg_wr     (reg_wr),
  .rx_avail   (rx_avail),
  .rx_pop     (rx_pop),
  .tx_push    (tx_push)
);

// File: tb/tb_scc_hostif.sv
module tb_scc_hostif;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2:0]      host_addr;
  logic            host_rd, host_wr;
  logic [7:0]      host_wdata, host_rdata;
  logic [3:0]      reg_idx;
  logic [7:0]      reg_wdata;
  logic [1:0]      reg_wr;
  logic [1:0][7:0] reg_rdata;
  logic [1:0]      rx_avail;
  logic [1:0][7:0] rx_data;
  logic [1:0]      rx_pop;
  logic [7:0]      tx_data;
  logic [1:0]      tx_push;

  int total = 0;
  int bad   = 0;

  // channel-side models
  logic [7:0] mem [2][16];
  int rx_taken [2];
  int rx_fill  [2];
  int tx_cnt   [2];
  logic [7:0] tx_last [2];
  int wr_cnt;

  always #4 clk = ~clk;

  scc_hostif dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .rx_avail(rx_avail), .rx_data(rx_data),
    .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push)
  );

  function automatic logic [7:0] init_v(int c, int r);
    return 8'(8'h40 + c * 16 + r);
  endfunction

  function automatic logic [7:0] wr_v(int c, int r);
    return 8'((c * 37 + r * 11) ^ 8'h9C);
  endfunction

  for (genvar c = 0; c < 2; c++) begin : g_model
    assign reg_rdata[c] = mem[c][reg_idx];
    assign rx_avail[c]  = (rx_taken[c] < rx_fill[c]);
    assign rx_data[c]   = 8'(176 + c * 8 + rx_taken[c]);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < 16; r++) mem[c][r] <= init_v(c, r);
        rx_taken[c] <= 0;
        tx_cnt[c]   <= 0;
        tx_last[c]  <= 8'h00;
      end
      wr_cnt <= 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (reg_wr[c]) mem[c][reg_idx] <= reg_wdata;
        if (rx_pop[c]) rx_taken[c] <= rx_taken[c] + 1;
        if (tx_push[c]) begin
          tx_cnt[c]  <= tx_cnt[c] + 1;
          tx_last[c] <= tx_data;
        end
      end
      wr_cnt <= wr_cnt + int'(reg_wr[0]) + int'(reg_wr[1]);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1; host_wr = 1'b0;
    #2 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    host_addr = a; host_wr = 1'b1; host_rd = 1'b0; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int wc, tc;
    rst_n = 1'b0; host_addr = '0; host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    rx_fill[0] = 0; rx_fill[1] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    chk("R11 ptr", int'(reg_idx), 0);
    do_rd(3'd0, d); chk("R11 reg0 via B", d, init_v(0, 0));
    do_wr(3'd1, 8'h02);
    do_rd(3'd1, d); chk("R11 vector", d, 0);

    // R1 R4 R5: write every register index of both channels
    for (int c = 0; c < 2; c++) begin
      for (int r = 1; r < 16; r++) begin
        if (r == 2) continue;
        do_wr(3'(c), 8'(8'hF0 | r));
        chk("R4 ptr load", int'(reg_idx), r);
        do_wr(3'(c), wr_v(c, r));
        chk("R5 ptr clear", int'(reg_idx), 0);
      end
    end
    chk("R5 write count", wr_cnt, 28);

    // R2: read back, pointer loaded via the other channel
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 16; r++) begin
        if (r == 2) continue;
        if (r != 0) do_wr(3'(1 - c), 8'(r));
        do_rd(3'(c), d);
        chk("R2 readback", d, (r == 0) ? init_v(c, 0) : wr_v(c, r));
      end
    end

    // R3: read clears pointer
    do_wr(3'd1, 8'h05);
    do_rd(3'd1, d); chk("R3 first", d, wr_v(1, 5));
    do_rd(3'd1, d); chk("R3 after clear", d, init_v(1, 0));

    // R6: shared vector
    wc = wr_cnt;
    do_wr(3'd0, 8'h02); do_wr(3'd0, 8'hA5);
    do_wr(3'd0, 8'h02); do_rd(3'd1, d); chk("R6 vec via A", d, 8'hA5);
    do_wr(3'd1, 8'h02); do_rd(3'd0, d); chk("R6 vec via B", d, 8'hA5);
    chk("R6 no reg write", wr_cnt, wc);

    // R7: receive path
    rx_fill[0] = 3; rx_fill[1] = 1;
    for (int k = 0; k < 4; k++) begin
      do_rd(3'd2, d); chk("R7 rx B", d, (k < 3) ? 176 + k : 8'hFF);
    end
    for (int k = 0; k < 2; k++) begin
      do_rd(3'd3, d); chk("R7 rx A", d, (k < 1) ? 184 : 8'hFF);
    end

    // R8: transmit path
    do_wr(3'd3, 8'h3C);
    chk("R8 tx A cnt", tx_cnt[1], 1); chk("R8 tx A data", tx_last[1], 8'h3C);
    chk("R8 tx B cnt", tx_cnt[0], 0);
    do_wr(3'd2, 8'hC3);
    chk("R8 tx B cnt2", tx_cnt[0], 1); chk("R8 tx B data", tx_last[0], 8'hC3);

    // R10: data accesses keep pointer
    do_wr(3'd0, 8'h06);
    do_rd(3'd3, d); do_wr(3'd2, 8'h11);
    chk("R10 ptr kept", int'(reg_idx), 6);
    do_rd(3'd0, d); chk("R10 target", d, wr_v(0, 6));

    // R9: reserved offsets
    wc = wr_cnt; tc = tx_cnt[0] + tx_cnt[1];
    do_wr(3'd1, 8'h09);
    for (int a = 4; a < 8; a++) begin
      do_rd(3'(a), d); chk("R9 rsv read", d, 0);
      do_wr(3'(a), 8'h03);
    end
    chk("R9 ptr kept", int'(reg_idx), 9);
    chk("R9 no reg write", wr_cnt, wc);
    chk("R9 no tx", tx_cnt[0] + tx_cnt[1], tc);
    do_rd(3'd1, d); chk("R9 target", d, wr_v(1, 9));

    // R12: read and write together
    rx_fill[0] = 4; tc = tx_cnt[0];
    @(negedge clk);
    host_addr = 3'd2; host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'h77;
    #2 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    chk("R12 read done", d, 179);
    chk("R12 write dropped", tx_cnt[0], tc);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule